// File: doc/BRIEF.md
# AES Round-Key Expander (Bidirectional, On Demand)

This block produces the round keys that an AES round datapath needs, one 128-bit key at a time. It never holds the whole schedule. A sliding window of up to eight 32-bit expanded-key words is stepped forward by four words for each key the consumer takes. A 128-, 192- or 256-bit cipher key is written word by word into an eight-word key window. The key is left-aligned: window word 0 holds the first, most significant key word. A start request then begins an encryption pass, which hands out round keys 0 to Nr in order.

Decryption needs the round keys in the opposite order. At the end of an encryption pass the block latches the final window contents and raises a decrypt-ready flag. A later decryption pass starts from that latched window and steps the expansion backwards, four words per key, from key Nr down to key 0. A decryption request made before any encryption pass has finished is refused, and an error flag is raised.

Top module: `aes_key_expander`

## Requirements
- R1: After reset `busy`, `rkValid`, `decReady` and `errFlag` are all 0.
- R2: An encryption pass with a 128-bit key (keySize 2'b00) delivers 11 round keys equal to the standard AES key expansion. Key k carries words 4k..4k+3, with word 4k in bits [127:96].
- R3: keySize 2'b01 selects a 192-bit key and 2'b10 selects a 256-bit key. Their passes deliver exactly 13 and 15 round keys, each equal to the standard expansion.
- R4: Key window word i is written through keyWrIdx = i, and word 0 is the first key word. A key of Nk words uses only window words 0..Nk-1, so values in the higher words have no effect on the keys produced.
- R5: A key transfers on each rising edge where `rkValid` and `rkReady` are both 1. While `rkValid` is 1 and `rkReady` is 0, `rkData` holds its value.
- R6: An accepted start sets `busy` on the next cycle, and `rkValid` equals `busy`. `busy` clears on the cycle after the last key of the pass is accepted.
- R7: Key writes made while `busy` is 1 are ignored. The next encryption pass uses the key as it stood before those writes.
- R8: A decryption request (startReq with startDec = 1) while `decReady` is 0 sets `errFlag` and leaves `busy` at 0. `errFlag` clears when a start is next accepted.
- R9: `decReady` sets on the cycle after an encryption pass ends. It clears on an accepted key write or an accepted encryption start.
- R10: A decryption pass delivers round keys Nr, Nr-1, ... down to 0 of the most recent completed encryption pass. It uses that pass's key size, whatever value keySize has at the time.
- R11: A start request made while `busy` is 1 is ignored and does not disturb the running pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| keyWrEn | input | 1 | Write strobe for one key window word |
| keyWrIdx | input | 3 | Key window word index (0 = first key word) |
| keyWrData | input | 32 | Key word to write |
| keySize | input | 2 | Key length for an encryption start: 00 = 128, 01 = 192, other values = 256 |
| startReq | input | 1 | Start a pass |
| startDec | input | 1 | With startReq: 1 = decryption pass, 0 = encryption pass |
| rkReady | input | 1 | Consumer accepts the presented round key |
| rkValid | output | 1 | A round key is presented |
| rkData | output | 128 | Current round key, first word in the top bits |
| busy | output | 1 | A pass is in progress |
| decReady | output | 1 | A final window is latched and decryption may start |
| errFlag | output | 1 | The last decryption request was refused |

## Verification
The assertions assume that key writes and start requests never fall in the same cycle as a decryption start. They also assume that `rkReady` changes only between clock edges. Otherwise the relative priority of the clear on `decReady` and the decryption accept would be open. The stimulus keeps writes, starts and ready changes in separate tasks and drives them just after a rising edge, so this never happens. It still injects a key write and a start request in the middle of a running pass to cover the ignore rules.

// File: rtl/aes_kx_pkg.sv
package aes_kx_pkg;

  localparam int KX_WW    = 32;
  localparam int KX_WORDS = 8;
  localparam int KX_LANES = 4;
  localparam int KX_IDX_W = $clog2(KX_WORDS);
  localparam int KX_RND_W = 4;
  localparam int KX_POS_W = KX_RND_W + 3;

  typedef logic [KX_WW-1:0] word_t;

  typedef struct packed {
    logic                keyWe;
    logic                loadFwd;
    logic                loadRev;
    logic                stepFwd;
    logic                stepRev;
    logic                saveEnd;
    logic [1:0]          nkSel;
    logic [KX_RND_W-1:0] round;
  } kxCtrl_t;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] aa;
    acc = '0;
    aa  = a;
    for (int n = 0; n < 8; n++) begin
      if (b[n]) acc = acc ^ aa;
      aa = xtime(aa);
    end
    return acc;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] inv;
    logic [7:0] sq;
    inv = 8'h01;
    sq  = x;
    for (int n = 1; n < 8; n++) begin
      sq  = gfMul(sq, sq);
      inv = gfMul(inv, sq);
    end
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
           {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

  function automatic word_t subWord(input word_t w);
    return {sbox(w[31:24]), sbox(w[23:16]), sbox(w[15:8]), sbox(w[7:0])};
  endfunction

  function automatic logic [7:0] rcon(input logic [KX_POS_W-1:0] q);
    logic [7:0] r;
    r = 8'h01;
    for (int n = 2; n < 16; n++) begin
      if (n <= int'(q)) r = xtime(r);
    end
    return r;
  endfunction

  function automatic int nkOf(input logic [1:0] sel);
    return (sel == 2'd0) ? 4 : (sel == 2'd1) ? 6 : 8;
  endfunction

  function automatic logic [KX_RND_W-1:0] nrOf(input logic [1:0] sel);
    return (sel == 2'd0) ? 4'd10 : (sel == 2'd1) ? 4'd12 : 4'd14;
  endfunction

  // Mixing term applied to the neighbour word when producing word idx
  function automatic word_t mixWord(input word_t prev, input logic [KX_POS_W-1:0] idx,
                                    input logic [1:0] sel);
    logic [KX_POS_W-1:0] m;
    logic [KX_POS_W-1:0] q;
    case (sel)
      2'd0:    begin m = idx & 7'd3; q = idx >> 2; end
      2'd1:    begin m = idx % 7'd6; q = idx / 7'd6; end
      default: begin m = idx & 7'd7; q = idx >> 3; end
    endcase
    if (m == '0)
      return subWord({prev[23:0], prev[31:24]}) ^ {rcon(q), 24'h0};
    else if (sel[1] && m == 7'd4)
      return subWord(prev);
    else
      return prev;
  endfunction

endpackage

// File: rtl/aesKxCtrl.sv
module aesKxCtrl
  import aes_kx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       keyWrEn,
  input  logic [1:0] keySize,
  input  logic       startReq,
  input  logic       startDec,
  input  logic       rkReady,
  output kxCtrl_t    ctl,
  output logic       busy,
  output logic       decReady,
  output logic       errFlag
);

  logic                isDec;
  logic [KX_RND_W-1:0] round;
  logic [1:0]          sizeSel;
  logic                accept;
  logic                hand;
  logic                lastKey;
  logic [1:0]          sizeIn;

  assign sizeIn  = (keySize == 2'b00) ? 2'd0 : (keySize == 2'b01) ? 2'd1 : 2'd2;
  assign accept  = startReq && !busy;
  assign hand    = busy && rkReady;
  assign lastKey = isDec ? (round == '0) : (round == nrOf(sizeSel));

  always_comb begin
    ctl.keyWe   = keyWrEn && !busy;
    ctl.loadFwd = accept && !startDec;
    ctl.loadRev = accept && startDec && decReady;
    ctl.stepFwd = hand && !isDec && !lastKey;
    ctl.stepRev = hand && isDec && !lastKey;
    ctl.saveEnd = hand && !isDec && lastKey;
    ctl.nkSel   = sizeSel;
    ctl.round   = round;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      isDec    <= 1'b0;
      round    <= '0;
      sizeSel  <= 2'd0;
      decReady <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      if (keyWrEn && !busy) decReady <= 1'b0;
      if (accept) begin
        if (startDec) begin
          if (decReady) begin
            busy    <= 1'b1;
            isDec   <= 1'b1;
            round   <= nrOf(sizeSel);
            errFlag <= 1'b0;
          end else begin
            errFlag <= 1'b1;
          end
        end else begin
          busy     <= 1'b1;
          isDec    <= 1'b0;
          round    <= '0;
          sizeSel  <= sizeIn;
          errFlag  <= 1'b0;
          decReady <= 1'b0;
        end
      end else if (hand) begin
        if (lastKey) begin
          busy <= 1'b0;
          if (!isDec) decReady <= 1'b1;
        end else if (isDec) begin
          round <= round - 1'b1;
        end else begin
          round <= round + 1'b1;
        end
      end
    end
  end

  p_dec_reject_r8: assert property (@(posedge clk) disable iff (!rstN)
    startReq && startDec && !busy && !decReady |=> !busy && errFlag);

  p_err_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !busy);

  p_hold_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    busy && !(rkReady && lastKey) |=> busy);

  p_round_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> round <= nrOf(sizeSel));

  p_ready_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy && !isDec && rkReady && lastKey |=> decReady && !busy);

  p_write_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    keyWrEn && !busy && !startReq |=> !decReady);

endmodule

// File: rtl/aesKxData.sv
module aesKxData
  import aes_kx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  kxCtrl_t             ctl,
  input  logic [KX_IDX_W-1:0] keyWrIdx,
  input  word_t               keyWrData,
  output logic [KX_LANES*KX_WW-1:0] rkData
);

  word_t keyReg [KX_WORDS];
  word_t win    [KX_WORDS];
  word_t endWin [KX_WORDS];
  word_t fwdNew [KX_LANES];
  word_t revNew [KX_LANES];
  word_t fwdWin [KX_WORDS];
  word_t revWin [KX_WORDS];

  // Forward: words p+nk .. p+nk+3 from the window holding p .. p+nk-1
  always_comb begin
    int nk;
    word_t prev;
    logic [KX_POS_W-1:0] idx;
    nk   = nkOf(ctl.nkSel);
    prev = win[KX_IDX_W'(nk - 1)];
    for (int k = 0; k < KX_LANES; k++) begin
      idx       = KX_POS_W'({ctl.round, 2'b00}) + KX_POS_W'(nk + k);
      fwdNew[k] = win[k] ^ mixWord(prev, idx, ctl.nkSel);
      prev      = fwdNew[k];
    end
    for (int j = 0; j < KX_WORDS; j++) begin
      if (j < nk - KX_LANES)
        fwdWin[j] = win[KX_IDX_W'(j + KX_LANES)];
      else if (j - (nk - KX_LANES) < KX_LANES)
        fwdWin[j] = fwdNew[2'(j - (nk - KX_LANES))];
      else
        fwdWin[j] = '0;
    end
  end

  // Reverse: words p-1 down to p-4, each from the words nk and nk-1 later
  always_comb begin
    int nk;
    int src;
    word_t prev;
    logic [KX_POS_W-1:0] idx;
    nk = nkOf(ctl.nkSel);
    for (int k = 0; k < KX_LANES; k++) begin
      idx  = KX_POS_W'({ctl.round, 2'b00}) + KX_POS_W'(nk) - KX_POS_W'(k + 1);
      src  = nk - 2 - k;
      prev = (src >= 0) ? win[KX_IDX_W'(src)] : revNew[0];
      revNew[k] = win[KX_IDX_W'(nk - 1 - k)] ^ mixWord(prev, idx, ctl.nkSel);
    end
    for (int j = 0; j < KX_WORDS; j++) begin
      if (j < KX_LANES)
        revWin[j] = revNew[2'(KX_LANES - 1 - j)];
      else
        revWin[j] = win[KX_IDX_W'(j - KX_LANES)];
    end
  end

  generate
    for (genvar g = 0; g < KX_WORDS; g++) begin : gWord
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          keyReg[g] <= '0;
          win[g]    <= '0;
          endWin[g] <= '0;
        end else begin
          if (ctl.keyWe && keyWrIdx == KX_IDX_W'(g)) keyReg[g] <= keyWrData;
          if (ctl.loadFwd)      win[g] <= keyReg[g];
          else if (ctl.loadRev) win[g] <= endWin[g];
          else if (ctl.stepFwd) win[g] <= fwdWin[g];
          else if (ctl.stepRev) win[g] <= revWin[g];
          if (ctl.saveEnd) endWin[g] <= win[g];
        end
      end
    end
    for (genvar l = 0; l < KX_LANES; l++) begin : gLane
      assign rkData[(KX_LANES-1-l)*KX_WW +: KX_WW] = win[l];
    end
  endgenerate

endmodule

// File: rtl/aes_key_expander.sv
module aes_key_expander
  import aes_kx_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         keyWrEn,
  input  logic [2:0]   keyWrIdx,
  input  logic [31:0]  keyWrData,
  input  logic [1:0]   keySize,
  input  logic         startReq,
  input  logic         startDec,
  input  logic         rkReady,
  output logic         rkValid,
  output logic [127:0] rkData,
  output logic         busy,
  output logic         decReady,
  output logic         errFlag
);

  kxCtrl_t ctl;

  aesKxCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .keyWrEn  (keyWrEn),
    .keySize  (keySize),
    .startReq (startReq),
    .startDec (startDec),
    .rkReady  (rkReady),
    .ctl      (ctl),
    .busy     (busy),
    .decReady (decReady),
    .errFlag  (errFlag)
  );

  aesKxData u_data (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .keyWrIdx  (keyWrIdx),
    .keyWrData (keyWrData),
    .rkData    (rkData)
  );

  assign rkValid = busy;

  p_stall_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    rkValid && !rkReady |=> $stable(rkData) && rkValid);

  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    startReq && !startDec && !busy |=> busy && rkValid);

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !startReq |=> !rkValid);

endmodule

// File: tb/test_aes_key_expander.sv
module test_aes_key_expander;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         keyWrEn = 1'b0;
  logic [2:0]   keyWrIdx = '0;
  logic [31:0]  keyWrData = '0;
  logic [1:0]   keySize = '0;
  logic         startReq = 1'b0;
  logic         startDec = 1'b0;
  logic         rkReady = 1'b0;
  logic         rkValid;
  logic [127:0] rkData;
  logic         busy;
  logic         decReady;
  logic         errFlag;

  always #2 clk = ~clk;

  aes_key_expander i_aes_key_expander (
    .clk(clk), .rstN(rstN), .keyWrEn(keyWrEn), .keyWrIdx(keyWrIdx),
    .keyWrData(keyWrData), .keySize(keySize), .startReq(startReq),
    .startDec(startDec), .rkReady(rkReady), .rkValid(rkValid),
    .rkData(rkData), .busy(busy), .decReady(decReady), .errFlag(errFlag)
  );

  int checks = 0;
  int errors = 0;
  int hs = 0;
  int cyc = 0;
  bit monOn = 0;
  bit kaOn = 0;
  string curReq = "R1";

  logic [7:0]  sb [256];
  logic [31:0] rc [16];
  logic [31:0] mKey [8];
  logic [31:0] mSched [64];
  int mNk = 4, mNr = 10, mIdx = 0;
  bit mBusy = 0, mDec = 0, mDecReady = 0, mErr = 0;

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return 8'((v << n) | (v >> (8 - n)));
  endfunction

  function automatic logic [31:0] subW(input logic [31:0] w);
    return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic expandModel();
    logic [31:0] t;
    for (int i = 0; i < mNk; i++) mSched[i] = mKey[i];
    for (int i = mNk; i < 64; i++) begin
      t = mSched[i-1];
      if (i % mNk == 0) t = subW({t[23:0], t[31:24]}) ^ rc[i / mNk];
      else if (mNk == 8 && i % mNk == 4) t = subW(t);
      mSched[i] = mSched[i-mNk] ^ t;
    end
  endtask

  function automatic logic [127:0] expKey(input int k);
    return {mSched[4*k], mSched[4*k+1], mSched[4*k+2], mSched[4*k+3]};
  endfunction

  // Behavioural reference, updated on every rising edge
  always @(posedge clk) begin
    if (monOn) begin
      cyc++;
      if (keyWrEn && !mBusy) begin
        mKey[keyWrIdx] = keyWrData;
        mDecReady = 0;
      end
      if (startReq && !mBusy) begin
        if (startDec) begin
          if (mDecReady) begin
            mBusy = 1; mDec = 1; mIdx = mNr; mErr = 0;
          end else mErr = 1;
        end else begin
          mNk = (keySize == 2'b00) ? 4 : (keySize == 2'b01) ? 6 : 8;
          mNr = mNk + 6;
          expandModel();
          mBusy = 1; mDec = 0; mIdx = 0; mErr = 0; mDecReady = 0;
        end
      end else if (mBusy && rkReady) begin
        if ((mDec && mIdx == 0) || (!mDec && mIdx == mNr)) begin
          mBusy = 0;
          if (!mDec) mDecReady = 1;
        end else if (mDec) mIdx--;
        else mIdx++;
      end
    end
  end

  // Comparison every clock, away from the active edge
  always @(negedge clk) begin
    if (monOn) begin
      chk(busy == mBusy, (curReq == "R11" || curReq == "R7") ? curReq : "R6", "busy",
          128'(busy), 128'(mBusy));
      chk(rkValid == mBusy, "R6", "rkValid", 128'(rkValid), 128'(mBusy));
      chk(decReady == mDecReady, "R9", "decReady", 128'(decReady), 128'(mDecReady));
      chk(errFlag == mErr, "R8", "errFlag", 128'(errFlag), 128'(mErr));
      if (mBusy) begin
        chk(rkData == expKey(mIdx), rkReady ? curReq : "R5", "rkData", rkData, expKey(mIdx));
        if (kaOn && !mDec && mIdx == 10)
          chk(rkData == 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R2", "known last key",
              rkData, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
      end
      if (rkValid && rkReady) hs++;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic writeKey(input int i, input logic [31:0] d);
    keyWrEn = 1; keyWrIdx = 3'(i); keyWrData = d;
    tick();
    keyWrEn = 0;
  endtask

  task automatic startPass(input bit dec, input logic [1:0] sz);
    hs = 0;
    startReq = 1; startDec = dec; keySize = sz;
    tick();
    startReq = 0; startDec = 0;
  endtask

  task automatic drain(input int mode, input bit poke);
    int n;
    n = 0;
    while (mBusy && n < 1000) begin
      rkReady = (mode == 0) ? 1'b1 : (mode == 1) ? 1'(n % 2) : 1'(n % 3 == 0);
      if (poke && n == 3) begin
        curReq = "R11";
        keyWrEn = 1; keyWrIdx = 3'd0; keyWrData = 32'hdeadbeef;
        startReq = 1; startDec = 1;
      end else begin
        keyWrEn = 0; startReq = 0; startDec = 0;
      end
      tick();
      n++;
    end
    rkReady = 0; keyWrEn = 0; startReq = 0; startDec = 0;
  endtask

  initial begin
    logic [7:0] p, q;
    logic [7:0] r;
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b00};
      q = q ^ {q[3:0], 4'h0};
      if (q[7]) q = q ^ 8'h09;
      sb[p] = q ^ rotl8(q, 1) ^ rotl8(q, 2) ^ rotl8(q, 3) ^ rotl8(q, 4) ^ 8'h63;
    end while (p != 8'h01);
    sb[0] = 8'h63;
    rc[0] = '0;
    r = 8'h01;
    for (int n = 1; n < 16; n++) begin
      rc[n] = {r, 24'h0};
      r = {r[6:0], 1'b0} ^ (r[7] ? 8'h1b : 8'h00);
    end
    for (int n = 0; n < 8; n++) mKey[n] = '0;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    chk(!busy && !rkValid && !decReady && !errFlag, "R1", "reset outputs",
        128'({busy, rkValid, decReady, errFlag}), 128'(0));
    monOn = 1;

    // 128-bit known key, junk in the unused upper words
    curReq = "R4";
    writeKey(0, 32'h2b7e1516); writeKey(1, 32'h28aed2a6);
    writeKey(2, 32'habf71588); writeKey(3, 32'h09cf4f3c);
    for (int i = 4; i < 8; i++) writeKey(i, 32'h5a5a0000 + i);
    chk(rkValid == 0 && busy == 0, "R6", "idle before start", 128'(busy), 128'(0));
    kaOn = 1;
    curReq = "R2";
    startPass(0, 2'b00);
    chk(rkData == 128'h2b7e151628aed2a6abf7158809cf4f3c, "R4", "first key is cipher key",
        rkData, 128'h2b7e151628aed2a6abf7158809cf4f3c);
    drain(0, 0);
    kaOn = 0;
    chk(hs == 11, "R2", "key count 128", 128'(hs), 128'(11));
    chk(decReady == 1, "R9", "decReady after pass", 128'(decReady), 128'(1));

    // Decrypt with stalls, keySize input set to something else
    curReq = "R10";
    startPass(1, 2'b10);
    drain(1, 0);
    chk(hs == 11, "R10", "reverse count 128", 128'(hs), 128'(11));

    // 192-bit key, with a write and a start injected mid-pass
    curReq = "R3";
    for (int i = 0; i < 6; i++) writeKey(i, 32'h8e73b0f7 ^ (32'h01010101 * i));
    startPass(0, 2'b01);
    drain(2, 1);
    chk(hs == 13, "R3", "key count 192", 128'(hs), 128'(13));
    curReq = "R7";
    startPass(0, 2'b01);
    chk(rkData[127:96] == 32'h8e73b0f7, "R7", "write while busy ignored",
        128'(rkData[127:96]), 128'(32'h8e73b0f7));
    drain(0, 0);
    curReq = "R10";
    startPass(1, 2'b00);
    drain(0, 0);
    chk(hs == 13, "R10", "reverse count 192", 128'(hs), 128'(13));

    // 256-bit key both directions
    curReq = "R3";
    for (int i = 0; i < 8; i++) writeKey(i, 32'h603deb10 + 32'h11111111 * i);
    startPass(0, 2'b10);
    drain(1, 0);
    chk(hs == 15, "R3", "key count 256", 128'(hs), 128'(15));
    curReq = "R10";
    startPass(1, 2'b00);
    drain(2, 0);
    chk(hs == 15, "R10", "reverse count 256", 128'(hs), 128'(15));

    // Key write drops decrypt-ready, refused decrypt, then recovery
    curReq = "R9";
    writeKey(0, 32'h00112233);
    chk(decReady == 0, "R9", "write clears decReady", 128'(decReady), 128'(0));
    curReq = "R8";
    startPass(1, 2'b00);
    chk(errFlag == 1 && busy == 0, "R8", "decrypt refused", 128'({errFlag, busy}), 128'(2'b10));
    startPass(0, 2'b00);
    chk(errFlag == 0 && busy == 1, "R8", "error cleared by start", 128'({errFlag, busy}), 128'(2'b01));
    drain(0, 0);
    chk(hs == 11, "R2", "key count after recovery", 128'(hs), 128'(11));
    tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule